// File: doc/BRIEF.md
# Per-Lane Parity Generator and Checker

This block sits on an 18-bit data path and manages one parity bit for each 9-bit lane. The lower lane holds bits 0 to 8 and the upper lane holds bits 9 to 17. In each lane the top bit (bit 8 or bit 17) is the parity position, and the lower eight bits are the payload. A held configuration picks one of three behaviours for the parity positions. They can pass through as plain data. They can be overwritten with parity computed over the payload. Or they can be replaced by a flag that reports whether the incoming parity bit matches its payload.

Words are presented with a valid strobe, and the result leaves through a single register stage. In check mode, the error flags therefore appear on the same clock edge as the payload they describe. The configuration is loaded with a strobe and resets to pass-through with even parity. One odd/even select applies to both lanes.

Top module: `parity_lane_unit`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid and out_data become zero, and the held configuration returns to pass-through with even parity.
- R2: out_valid equals the in_valid value sampled at the previous clock edge, so each accepted word appears one cycle after it is presented.
- R3: In pass-through mode (cfg_mode = 0), out_data equals the accepted in_data on all 18 bits.
- R4: In generate mode (cfg_mode = 1), output bits 0-7 and 9-16 equal the input bits, and input bits 8 and 17 have no effect on the output.
- R5: In generate mode, output bit 8 is the XOR of input bits 0-7 and output bit 17 is the XOR of input bits 9-16 when cfg_odd = 0; when cfg_odd = 1, both are inverted.
- R6: In check mode (cfg_mode = 2), output bit 8 (lower lane) and output bit 17 (upper lane) are high exactly when the incoming parity bit differs from the parity that R5 would generate for that lane's payload. The payload bits pass unchanged.
- R7: cfg_mode and cfg_odd are captured only at an edge where cfg_load is high, and they govern every word accepted after that edge. Changes to them without cfg_load have no effect.
- R8: The reserved code cfg_mode = 3 behaves as pass-through.
- R9: At an edge where in_valid is low, out_data keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Capture strobe for cfg_mode and cfg_odd |
| cfg_mode | input | 2 | 0 pass, 1 generate, 2 check, 3 reserved (pass) |
| cfg_odd | input | 1 | 1 selects odd parity, 0 even, for both lanes |
| in_valid | input | 1 | in_data holds a word to process |
| in_data | input | 18 | Input word, two 9-bit lanes |
| out_valid | output | 1 | out_data holds a newly processed word |
| out_data | output | 18 | Processed word |

## Verification
The bench builds the block with its default parameters: two lanes of nine bits each. This places the parity positions at bits 8 and 17, which is what the requirements name. With that shape, both flag positions can be driven independently. A corrupted parity bit in one lane must raise only that lane's flag. Input patterns with all-ones and single-bit payloads exercise both parity polarities, in every mode and under both odd and even selection.

// File: rtl/parity_lane_pkg.sv
// Package: shared mode encoding for the per-lane parity block.
// Assumes a 2-bit configuration code; code 3 is reserved and treated as pass.
package parity_lane_pkg;

    typedef enum logic [1:0] {
        PM_PASS = 2'd0,
        PM_GEN  = 2'd1,
        PM_CHK  = 2'd2,
        PM_RSV  = 2'd3
    } par_mode_e;

endpackage

// File: rtl/plg_cfg_reg.sv
// Module: plg_cfg_reg
// Holds the parity mode and odd/even select. It loads them on a strobe and
// resets to pass-through with even parity. Assumes a synchronous active-low reset.
module plg_cfg_reg
    import parity_lane_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [1:0] mode_i,
    input  logic       odd_i,
    output par_mode_e  mode_o,
    output logic       odd_o
);

    // Capture the configuration on load; restore the default on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= PM_PASS;
            odd_o  <= 1'b0;
        end else if (load_i) begin
            mode_o <= par_mode_e'(mode_i);
            odd_o  <= odd_i;
        end
    end

endmodule

// File: rtl/plg_lane.sv
// Module: plg_lane
// Combinational processing of one lane. The top bit is the parity position;
// the bits below it form the payload. Depending on the mode, the top bit is
// passed, replaced by generated parity, or replaced by a mismatch flag.
// Assumes LANE_BITS >= 2.
module plg_lane
    import parity_lane_pkg::*;
#(
    parameter int LANE_BITS = 9
) (
    input  logic [LANE_BITS-1:0] din_i,
    input  par_mode_e            mode_i,
    input  logic                 odd_i,
    output logic [LANE_BITS-1:0] dout_o
);

    localparam int PPOS = LANE_BITS - 1;

    logic gen_par;

    // Parity over the payload; odd select inverts it.
    always_comb begin
        gen_par = (^din_i[PPOS-1:0]) ^ odd_i;
    end

    // Pick the meaning of the parity position from the mode.
    always_comb begin
        dout_o = din_i;
        case (mode_i)
            PM_GEN:  dout_o[PPOS] = gen_par;
            PM_CHK:  dout_o[PPOS] = din_i[PPOS] ^ gen_par;
            default: dout_o[PPOS] = din_i[PPOS];
        endcase
    end

endmodule

// File: rtl/plg_out_stage.sv
// Module: plg_out_stage
// Output register for the processed word and its valid bit. The word is
// loaded only for valid input and held otherwise. Synchronous active-low reset.
module plg_out_stage #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [WIDTH-1:0] data_i,
    output logic             valid_o,
    output logic [WIDTH-1:0] data_o
);

    // Register valid every cycle; register data only when valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                data_o <= data_i;
            end
        end
    end

endmodule

// File: rtl/parity_lane_unit.sv
// Module: parity_lane_unit
// Top of the per-lane parity generator/checker. The data word is split into
// NUM_LANES lanes of LANE_BITS bits, each processed by its own lane slice.
// The result is registered once, so check flags leave with their data.
// Assumes a single clock and a synchronous active-low reset.
module parity_lane_unit
    import parity_lane_pkg::*;
#(
    parameter int NUM_LANES = 2,
    parameter int LANE_BITS = 9
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_load,
    input  logic [1:0]                     cfg_mode,
    input  logic                           cfg_odd,
    input  logic                           in_valid,
    input  logic [NUM_LANES*LANE_BITS-1:0] in_data,
    output logic                           out_valid,
    output logic [NUM_LANES*LANE_BITS-1:0] out_data
);

    localparam int DATA_W = NUM_LANES * LANE_BITS;

    par_mode_e          mode_q;
    logic               odd_q;
    logic [DATA_W-1:0]  lane_out;

    plg_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cfg_load),
        .mode_i (cfg_mode),
        .odd_i  (cfg_odd),
        .mode_o (mode_q),
        .odd_o  (odd_q)
    );

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        plg_lane #(.LANE_BITS(LANE_BITS)) u_lane (
            .din_i  (in_data[l*LANE_BITS +: LANE_BITS]),
            .mode_i (mode_q),
            .odd_i  (odd_q),
            .dout_o (lane_out[l*LANE_BITS +: LANE_BITS])
        );
    end

    plg_out_stage #(.WIDTH(DATA_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (in_valid),
        .data_i  (lane_out),
        .valid_o (out_valid),
        .data_o  (out_data)
    );

endmodule

// File: rtl/parity_lane_unit_chk.sv
// Module: parity_lane_unit_chk
// Assertion checker for parity_lane_unit, bound to every instance of it.
module parity_lane_unit_chk #(
    parameter int NUM_LANES = 2,
    parameter int LANE_BITS = 9
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           in_valid,
    input logic [NUM_LANES*LANE_BITS-1:0] in_data,
    input logic                           out_valid,
    input logic [NUM_LANES*LANE_BITS-1:0] out_data,
    input logic [1:0]                     mode_q,
    input logic                           odd_q
);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

    // R3 and R8: pass and reserved codes forward the full word.
    a_r3_pass_word: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mode_q == 2'd0 || mode_q == 2'd3)) |=> out_data == $past(in_data));

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lchk
        localparam int BASE = l * LANE_BITS;
        localparam int TOPB = BASE + LANE_BITS - 1;

        a_r4_gen_payload: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && mode_q == 2'd1) |=>
                out_data[TOPB-1:BASE] == $past(in_data[TOPB-1:BASE]));

        a_r5_gen_parity: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && mode_q == 2'd1) |=>
                out_data[TOPB] == ((^$past(in_data[TOPB-1:BASE])) ^ $past(odd_q)));

        a_r6_check_flag: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && mode_q == 2'd2) |=>
                out_data[TOPB] == ((^$past(in_data[TOPB:BASE])) ^ $past(odd_q)));
    end

endmodule

bind parity_lane_unit parity_lane_unit_chk #(
    .NUM_LANES (NUM_LANES),
    .LANE_BITS (LANE_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .mode_q    (mode_q),
    .odd_q     (odd_q)
);

// File: tb/parity_lane_unit_test.sv
module parity_lane_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic        cfg_odd = 1'b0;
    logic        in_valid = 1'b0;
    logic [17:0] in_data = '0;
    logic        out_valid;
    logic [17:0] out_data;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    logic [17:0] exp_q[$];
    string       tag_q[$];
    logic [1:0]  sh_mode = 2'd0;
    logic        sh_odd = 1'b0;
    logic [17:0] last_exp = '0;

    always #2 clk = ~clk;   // 250 MHz

    parity_lane_unit uut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
        .cfg_odd(cfg_odd), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic par8(input logic [7:0] b, input logic odd);
        return (^b) ^ odd;
    endfunction

    function automatic logic [17:0] model(input logic [17:0] d, input logic [1:0] m, input logic odd);
        logic [17:0] r;
        r = d;
        if (m == 2'd1) begin
            r[8]  = par8(d[7:0], odd);
            r[17] = par8(d[16:9], odd);
        end else if (m == 2'd2) begin
            r[8]  = d[8]  ^ par8(d[7:0], odd);
            r[17] = d[17] ^ par8(d[16:9], odd);
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: present one word and push its expected result.
    task automatic send(input logic [17:0] d, input string req);
        @(negedge clk);
        cfg_load = 1'b0;
        in_valid = 1'b1;
        in_data  = d;
        last_exp = model(d, sh_mode, sh_odd);
        exp_q.push_back(last_exp);
        tag_q.push_back(req);
    endtask

    task automatic idle();
        @(negedge clk);
        cfg_load = 1'b0;
        in_valid = 1'b0;
    endtask

    task automatic load(input logic [1:0] m, input logic odd);
        @(negedge clk);
        in_valid = 1'b0;
        cfg_load = 1'b1;
        cfg_mode = m;
        cfg_odd  = odd;
        sh_mode  = m;
        sh_odd   = odd;
    endtask

    // Change configuration lines without the load strobe (R7).
    task automatic poke(input logic [1:0] m, input logic odd);
        @(negedge clk);
        in_valid = 1'b0;
        cfg_load = 1'b0;
        cfg_mode = m;
        cfg_odd  = odd;
    endtask

    // Monitor: compare each produced word against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_errors++;
                $display("FAIL R2: actual unexpected word %h expected none", out_data);
            end else begin
                check(tag_q.pop_front(), out_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        in_valid = 1'b1;
        in_data  = 18'h3FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs cleared during reset
        check("R1 valid", {17'd0, out_valid}, 18'd0);
        check("R1 data", out_data, 18'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        // R1: default config is pass-through
        send(18'h20100, "R1 default pass");
        send(18'h2A5C3, "R3 pass");
        send(18'h15A3C, "R3 pass");
        idle();
        idle();
        @(negedge clk);
        check("R2 idle valid", {17'd0, out_valid}, 18'd0);
        check("R9 hold", out_data, last_exp);

        // Generate, even parity
        load(2'd1, 1'b0);
        send(18'h00001, "R5 gen even single bit");
        send(18'h3FFFF, "R4 gen ignores 8/17 all ones");
        send(18'h000FF, "R5 gen even ff");
        send(18'h20100, "R4 gen ignores 8/17 set");
        // Generate, odd parity
        load(2'd1, 1'b1);
        send(18'h00000, "R5 gen odd zero");
        send(18'h00203, "R5 gen odd mix");
        send(18'h3FEFF, "R4 gen odd");

        // Check, even
        load(2'd2, 1'b0);
        send(18'h00001, "R6 chk lower lane err");
        send(18'h00101, "R6 chk lower lane ok");
        send(18'h00200, "R6 chk upper lane err");
        send(18'h20200, "R6 chk upper lane ok");
        send(18'h3FFFF, "R6 chk both");
        // Check, odd
        load(2'd2, 1'b1);
        send(18'h00000, "R6 chk odd both err");
        send(18'h20100, "R6 chk odd both ok");

        // Reserved code behaves as pass
        load(2'd3, 1'b1);
        send(18'h2A5C3, "R8 reserved pass");
        send(18'h00100, "R8 reserved pass");

        // Lines changed without load are ignored
        poke(2'd1, 1'b0);
        send(18'h00001, "R7 no-load ignored");
        load(2'd1, 1'b0);
        poke(2'd2, 1'b1);
        send(18'h00007, "R7 load applied");

        idle();
        idle();
        idle();
        @(negedge clk);
        check("R9 hold end", out_data, last_exp);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_errors++;
            $display("FAIL R2: actual %0d pending expected 0", exp_q.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule